// File: doc/BRIEF.md
# Protected Address Translation Buffer

This block holds a small set of recent virtual-to-physical page mappings and answers address lookups against all of them at once. A lookup presents a 32-bit virtual address, the running process identifier, the kind of access (read, write or instruction fetch) and a privileged-mode flag. One cycle later the block reports exactly one outcome. A hit carries the 30-bit physical address. A miss means no usable mapping is held. An access fault means a mapping matched but its permissions forbid the access. Pages are 4 KB. The low 12 address bits pass through untranslated, and the 20-bit virtual page number is swapped for an 18-bit physical page number.

After a miss, external logic reads the page table and installs the mapping through the refill port. A refill reuses any entry that already holds the same page and process. Otherwise it takes the lowest-numbered empty entry, and when no entry is empty it evicts one chosen by a free-running pseudo-random register. Each entry keeps a used flag and a modified flag. These are set by successful lookups and reported alongside each result, so outside logic can track page activity. On a context switch the block can drop every mapping, or only the mappings of one process.

Top module: `xlat_buffer`

## Requirements
- R1: On a hit, `rs_paddr` equals the entry's 18-bit physical page number in bits 29..12 and `lk_vaddr[11:0]` in bits 11..0; the page number compared is `lk_vaddr[31:12]`.
- R2: A lookup presented at a clock edge produces `rs_valid` at the next edge with exactly one of `rs_hit`, `rs_miss`, `rs_fault` set; with no lookup all four are 0.
- R3: A hit needs a valid entry whose page number and process identifier both equal the request; otherwise the result is a miss with `rs_paddr` = 0.
- R4: Access code 2'b00 is read and needs permission bit 2, 2'b01 is write and needs bit 1, 2'b10 is fetch and needs bit 0, and 2'b11 is handled as read. A matching entry that lacks the needed bit gives a fault with `rs_paddr` = 0.
- R5: With `lk_super` = 1 the permission check is skipped, and a matching entry always hits.
- R6: A write that hits sets the entry's modified flag. A faulting write leaves it unchanged.
- R7: Every hit sets the entry's used flag, and a fault sets neither flag. `rs_dirty` and `rs_ref` report the matched entry's flags as they stood before that lookup, and are 0 on a miss.
- R8: A refill whose page number and process identifier are already present overwrites that entry in place, so no two entries ever match one request. Every refilled entry starts with both flags clear.
- R9: While an entry is empty, a refill evicts no valid mapping. When all entries are full, a new mapping displaces exactly one old mapping.
- R10: `fl_all` invalidates every entry, and a refill offered in the same cycle as `fl_all` or `fl_pid_valid` is dropped.
- R11: `fl_pid_valid` invalidates only the entries whose process identifier equals `fl_pid`.
- R12: After reset every entry is empty and every result output is 0.
- R13: A lookup sees the contents as they were before the same edge's refill, flush or purge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_pid | input | PID_W | Process identifier of the request |
| lk_acc | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 read |
| lk_super | input | 1 | Privileged mode, bypasses permissions |
| rf_valid | input | 1 | Install a mapping |
| rf_vpn | input | 20 | Virtual page number to install |
| rf_pid | input | PID_W | Process identifier to install |
| rf_ppn | input | 18 | Physical page number to install |
| rf_perm | input | 3 | Permissions: bit 2 read, bit 1 write, bit 0 fetch |
| fl_all | input | 1 | Invalidate every entry |
| fl_pid_valid | input | 1 | Invalidate the entries of `fl_pid` |
| fl_pid | input | PID_W | Process whose entries are purged |
| rs_valid | output | 1 | Result present |
| rs_hit | output | 1 | Translation granted |
| rs_miss | output | 1 | No matching mapping |
| rs_fault | output | 1 | Mapping found, access forbidden |
| rs_paddr | output | 30 | Physical address on a hit, else 0 |
| rs_dirty | output | 1 | Matched entry's modified flag before this lookup |
| rs_ref | output | 1 | Matched entry's used flag before this lookup |

## Verification
The assertions assume that inputs are stable at the clock edge and that `lk_acc` is always driven to a known value. They do not assume that purge and refill are kept apart, because the design itself drops a refill that meets a flush. The random stimulus draws page numbers and process identifiers from small pools, so that hits, faults, overwrites and purges all occur often. It keeps the number of live mappings at most the entry count, so that the bench's reference model stays exact. The full-buffer eviction case is covered by a separate directed sequence that counts surviving mappings rather than naming the evicted one.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PA_W  = 30;
  localparam int PPN_W = PA_W - OFF_W;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_ALT   = 2'b11
  } acc_e;

  // permission bits: [2] read, [1] write, [0] fetch
  function automatic logic perm_ok(input logic [2:0] perm, input logic [1:0] acc,
                                   input logic sup);
    logic need;
    case (acc_e'(acc))
      ACC_WRITE: need = perm[1];
      ACC_FETCH: need = perm[0];
      default:   need = perm[2];
    endcase
    return sup | need;
  endfunction

  function automatic logic [PA_W-1:0] make_pa(input logic [PPN_W-1:0] ppn,
                                              input logic [VA_W-1:0] va);
    return {ppn, va[OFF_W-1:0]};
  endfunction
endpackage

// File: rtl/xlat_match.sv
module xlat_match
  import xlat_pkg::*;
#(
  parameter int N     = 16,
  parameter int PID_W = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N-1:0]               valid_vec,
  input  logic [N-1:0][VPN_W-1:0]    tags,
  input  logic [N-1:0][PID_W-1:0]    pids,
  input  logic [VPN_W-1:0]           key_vpn,
  input  logic [PID_W-1:0]           key_pid,
  output logic                       hit_any,
  output logic [IDX_W-1:0]           hit_idx
);
  logic [N-1:0] hit_vec;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid_vec[g] && (tags[g] == key_vpn) && (pids[g] == key_pid);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++)
      if (hit_vec[i]) hit_idx = IDX_W'(i);
  end

  assign hit_any = |hit_vec;

  // at most one entry matches any key: refills overwrite duplicates
  assert_unique_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N      = 16,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid_vec,
  input  logic             dup_any,
  input  logic [IDX_W-1:0] dup_idx,
  output logic [IDX_W-1:0] victim
);
  logic [LFSR_W-1:0] lfsr_q;
  logic              fb;
  logic              have_free;
  logic [IDX_W-1:0]  free_idx;
  logic [IDX_W-1:0]  rand_idx;

  assign fb = lfsr_q[LFSR_W-1] ^ lfsr_q[LFSR_W-3] ^ lfsr_q[LFSR_W-4] ^ lfsr_q[LFSR_W-6];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!valid_vec[i]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
  end

  assign rand_idx = IDX_W'(lfsr_q % LFSR_W'(N));

  always_comb begin
    if (dup_any)        victim = dup_idx;
    else if (have_free) victim = free_idx;
    else                victim = rand_idx;
  end

  assert_victim_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(victim) < N);
  assert_lfsr_alive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
  assert_free_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dup_any && !(&valid_vec)) |-> !valid_vec[victim]);
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter int N     = 16,
  parameter int PID_W = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [PID_W-1:0]  lk_pid,
  input  logic [1:0]        lk_acc,
  input  logic              lk_super,
  input  logic              rf_valid,
  input  logic [VPN_W-1:0]  rf_vpn,
  input  logic [PID_W-1:0]  rf_pid,
  input  logic [PPN_W-1:0]  rf_ppn,
  input  logic [2:0]        rf_perm,
  input  logic              fl_all,
  input  logic              fl_pid_valid,
  input  logic [PID_W-1:0]  fl_pid,
  output logic              rs_valid,
  output logic              rs_hit,
  output logic              rs_miss,
  output logic              rs_fault,
  output logic [PA_W-1:0]   rs_paddr,
  output logic              rs_dirty,
  output logic              rs_ref
);
  logic [N-1:0]              valid_q, dirty_q, ref_q;
  logic [N-1:0][VPN_W-1:0]   tag_q;
  logic [N-1:0][PID_W-1:0]   pid_q;
  logic [N-1:0][2:0]         perm_q;
  logic [N-1:0][PPN_W-1:0]   ppn_q;

  // lookup events
  logic             m_hit;
  logic [IDX_W-1:0] m_idx;
  logic             lk_pass, lk_grant, lk_deny, lk_is_write;

  // refill events
  logic             dup_any, rf_go;
  logic [IDX_W-1:0] dup_idx, vic_idx;

  xlat_match #(.N(N), .PID_W(PID_W)) i_look_match (
    .clk, .rst_n, .valid_vec(valid_q), .tags(tag_q), .pids(pid_q),
    .key_vpn(lk_vaddr[VA_W-1:OFF_W]), .key_pid(lk_pid),
    .hit_any(m_hit), .hit_idx(m_idx));

  xlat_match #(.N(N), .PID_W(PID_W)) i_fill_match (
    .clk, .rst_n, .valid_vec(valid_q), .tags(tag_q), .pids(pid_q),
    .key_vpn(rf_vpn), .key_pid(rf_pid),
    .hit_any(dup_any), .hit_idx(dup_idx));

  xlat_victim #(.N(N)) i_victim (
    .clk, .rst_n, .valid_vec(valid_q), .dup_any, .dup_idx, .victim(vic_idx));

  assign lk_pass     = perm_ok(perm_q[m_idx], lk_acc, lk_super);
  assign lk_grant    = lk_valid && m_hit && lk_pass;
  assign lk_deny     = lk_valid && m_hit && !lk_pass;
  assign lk_is_write = (acc_e'(lk_acc) == ACC_WRITE);
  assign rf_go       = rf_valid && !fl_all && !fl_pid_valid;

  // entry state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      ref_q   <= '0;
      tag_q   <= '0;
      pid_q   <= '0;
      perm_q  <= '0;
      ppn_q   <= '0;
    end else begin
      if (lk_grant) begin
        ref_q[m_idx] <= 1'b1;
        if (lk_is_write) dirty_q[m_idx] <= 1'b1;
      end
      if (rf_go) begin
        valid_q[vic_idx] <= 1'b1;
        dirty_q[vic_idx] <= 1'b0;
        ref_q[vic_idx]   <= 1'b0;
        tag_q[vic_idx]   <= rf_vpn;
        pid_q[vic_idx]   <= rf_pid;
        perm_q[vic_idx]  <= rf_perm;
        ppn_q[vic_idx]   <= rf_ppn;
      end
      if (fl_all) valid_q <= '0;
      else if (fl_pid_valid) begin
        for (int i = 0; i < N; i++)
          if (pid_q[i] == fl_pid) valid_q[i] <= 1'b0;
      end
    end
  end

  // result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_miss  <= 1'b0;
      rs_fault <= 1'b0;
      rs_paddr <= '0;
      rs_dirty <= 1'b0;
      rs_ref   <= 1'b0;
    end else begin
      rs_valid <= lk_valid;
      rs_hit   <= lk_grant;
      rs_miss  <= lk_valid && !m_hit;
      rs_fault <= lk_deny;
      rs_paddr <= lk_grant ? make_pa(ppn_q[m_idx], lk_vaddr) : '0;
      rs_dirty <= lk_valid && m_hit && dirty_q[m_idx];
      rs_ref   <= lk_valid && m_hit && ref_q[m_idx];
    end
  end

  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> $countones({rs_hit, rs_miss, rs_fault}) == 1);
  assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |-> !(rs_hit || rs_miss || rs_fault));
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rs_valid);
  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_grant |=> rs_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]));
  assert_fault_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_fault || rs_miss) |-> rs_paddr == '0);
  assert_dirty_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_grant && lk_is_write && !(rf_go && vic_idx == m_idx)) |=> dirty_q[$past(m_idx)]);
  assert_flush_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fl_all |=> valid_q == '0);
  assert_fill_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_go && !(fl_all || fl_pid_valid)) |=> valid_q[$past(vic_idx)] && !dirty_q[$past(vic_idx)]);
endmodule

// File: tb/test_xlat_buffer.sv
module test_xlat_buffer;
  localparam int N = 16;
  localparam int PW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, lk_super = 0, rf_valid = 0, fl_all = 0, fl_pid_valid = 0;
  logic [31:0] lk_vaddr = '0;
  logic [PW-1:0] lk_pid = '0, rf_pid = '0, fl_pid = '0;
  logic [1:0] lk_acc = '0;
  logic [19:0] rf_vpn = '0;
  logic [17:0] rf_ppn = '0;
  logic [2:0] rf_perm = '0;
  logic rs_valid, rs_hit, rs_miss, rs_fault, rs_dirty, rs_ref;
  logic [29:0] rs_paddr;

  int total = 0, bad = 0;

  // reference model
  bit m_v[N], m_d[N], m_r[N];
  logic [19:0] m_vpn[N];
  logic [PW-1:0] m_pid[N];
  logic [17:0] m_ppn[N];
  logic [2:0] m_perm[N];

  xlat_buffer #(.N(N), .PID_W(PW)) i_xlat_buffer (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit need_ok(input logic [2:0] perm, input logic [1:0] acc, input bit sup);
    logic [2:0] mask;
    mask = (acc == 2'd1) ? 3'b010 : (acc == 2'd2) ? 3'b001 : 3'b100;
    return sup || ((perm & mask) != 0);
  endfunction

  function automatic int m_find(input logic [19:0] vpn, input logic [PW-1:0] pid);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == vpn && m_pid[i] == pid) return i;
    return -1;
  endfunction

  function automatic int m_count();
    int c = 0;
    for (int i = 0; i < N; i++) c += m_v[i];
    return c;
  endfunction

  task automatic m_fill(input logic [19:0] vpn, input logic [PW-1:0] pid,
                        input logic [17:0] ppn, input logic [2:0] perm);
    int k = m_find(vpn, pid);
    if (k < 0)
      for (int i = N - 1; i >= 0; i--) if (!m_v[i]) k = i;
    if (k >= 0) begin
      m_v[k] = 1; m_d[k] = 0; m_r[k] = 0;
      m_vpn[k] = vpn; m_pid[k] = pid; m_ppn[k] = ppn; m_perm[k] = perm;
    end
  endtask

  task automatic m_purge(input logic [PW-1:0] pid);
    for (int i = 0; i < N; i++) if (m_pid[i] == pid) m_v[i] = 0;
  endtask

  task automatic m_clear();
    for (int i = 0; i < N; i++) m_v[i] = 0;
  endtask

  task automatic refill(input logic [19:0] vpn, input logic [PW-1:0] pid,
                        input logic [17:0] ppn, input logic [2:0] perm);
    @(negedge clk);
    rf_valid = 1; rf_vpn = vpn; rf_pid = pid; rf_ppn = ppn; rf_perm = perm;
    @(negedge clk);
    rf_valid = 0;
    m_fill(vpn, pid, ppn, perm);
  endtask

  task automatic purge(input logic [PW-1:0] pid);
    @(negedge clk);
    fl_pid_valid = 1; fl_pid = pid;
    @(negedge clk);
    fl_pid_valid = 0;
    m_purge(pid);
  endtask

  task automatic flush();
    @(negedge clk);
    fl_all = 1;
    @(negedge clk);
    fl_all = 0;
    m_clear();
  endtask

  // one lookup, checked against the model, model updated afterwards
  task automatic look(input logic [31:0] va, input logic [PW-1:0] pid,
                      input logic [1:0] acc, input bit sup, input string req);
    int k = m_find(va[31:12], pid);
    bit eh, em, ef, ed, er;
    logic [29:0] ep;
    em = (k < 0);
    eh = !em && need_ok(m_perm[k], acc, sup);
    ef = !em && !eh;
    ep = eh ? {m_ppn[k], va[11:0]} : 30'd0;
    ed = !em && m_d[k];
    er = !em && m_r[k];
    @(negedge clk);
    lk_valid = 1; lk_vaddr = va; lk_pid = pid; lk_acc = acc; lk_super = sup;
    @(negedge clk);
    lk_valid = 0;
    chk(rs_valid && rs_hit == eh && rs_miss == em && rs_fault == ef,
        {req, " outcome"}, {rs_valid, rs_hit, rs_miss, rs_fault}, {1'b1, eh, em, ef});
    chk(rs_paddr == ep, {req, " paddr"}, rs_paddr, ep);
    chk(rs_dirty == ed && rs_ref == er, {req, " flags"}, {rs_dirty, rs_ref}, {ed, er});
    if (eh) begin
      m_r[k] = 1;
      if (acc == 2'd1) m_d[k] = 1;
    end
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hits;
    void'($urandom(32'd7341));
    m_clear();
    repeat (3) @(negedge clk);
    chk({rs_valid, rs_hit, rs_miss, rs_fault, rs_paddr} == 0, "R12 reset outputs",
        {rs_valid, rs_hit, rs_miss, rs_fault, rs_paddr}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!rs_valid, "R2 idle result", rs_valid, 0);
    look(32'h1234_5678, 8'd1, 2'd0, 1, "R12 empty after reset");

    // R1 / R3
    refill(20'hABCDE, 8'd1, 18'h2_5A5A, 3'b111);
    look(32'hABCD_E123, 8'd1, 2'd0, 0, "R1 translate");
    look(32'hABCD_E123, 8'd2, 2'd0, 0, "R3 pid mismatch");
    look(32'hABCD_F123, 8'd1, 2'd0, 0, "R3 vpn mismatch");

    // R4 / R5 / R6 / R7
    refill(20'h00010, 8'd3, 18'h0_1111, 3'b100);
    look(32'h0001_0004, 8'd3, 2'd1, 0, "R4 write denied");
    look(32'h0001_0008, 8'd3, 2'd2, 0, "R4 fetch denied");
    look(32'h0001_000C, 8'd3, 2'd3, 0, "R4 code 11 as read");
    look(32'h0001_0010, 8'd3, 2'd1, 1, "R5 privileged write");
    look(32'h0001_0014, 8'd3, 2'd0, 0, "R6 dirty seen, R7 ref seen");
    refill(20'h00020, 8'd3, 18'h0_2222, 3'b001);
    look(32'h0002_0000, 8'd3, 2'd1, 0, "R6 faulting write no dirty");
    look(32'h0002_0000, 8'd3, 2'd2, 0, "R7 fault set no ref");
    look(32'h0002_0000, 8'd3, 2'd2, 0, "R7 ref after hit");

    // R8: overwrite in place, flags cleared
    refill(20'h00010, 8'd3, 18'h3_3333, 3'b110);
    look(32'h0001_0abc, 8'd3, 2'd0, 0, "R8 overwrite");

    // R13: lookup in same cycle as refill sees old contents
    @(negedge clk);
    rf_valid = 1; rf_vpn = 20'h00777; rf_pid = 8'd5; rf_ppn = 18'h0_0777; rf_perm = 3'b100;
    lk_valid = 1; lk_vaddr = 32'h0077_7000; lk_pid = 8'd5; lk_acc = 2'd0; lk_super = 0;
    @(negedge clk);
    rf_valid = 0; lk_valid = 0;
    chk(rs_miss && !rs_hit, "R13 concurrent refill", {rs_hit, rs_miss}, 2'b01);
    m_fill(20'h00777, 8'd5, 18'h0_0777, 3'b100);
    look(32'h0077_7000, 8'd5, 2'd0, 0, "R13 visible next");

    // R11 purge
    purge(8'd3);
    look(32'h0001_0000, 8'd3, 2'd0, 1, "R11 purged");
    look(32'hABCD_E000, 8'd1, 2'd0, 1, "R11 other pid kept");

    // R10 flush drops concurrent refill
    @(negedge clk);
    fl_all = 1; rf_valid = 1; rf_vpn = 20'h00999; rf_pid = 8'd1; rf_ppn = 18'h1; rf_perm = 3'b111;
    @(negedge clk);
    fl_all = 0; rf_valid = 0;
    m_clear();
    look(32'h0099_9000, 8'd1, 2'd0, 1, "R10 refill dropped");
    look(32'hABCD_E000, 8'd1, 2'd0, 1, "R10 flushed");

    // R9 / R8: fill all with one duplicate refill in between
    refill(20'h40000, 8'd9, 18'h0_4000, 3'b111);
    refill(20'h40000, 8'd9, 18'h0_4001, 3'b111);
    for (int i = 1; i < N; i++) refill(20'h40000 + 20'(i), 8'd9, 18'h0_4000 + 18'(i) + 1, 3'b111);
    for (int i = 0; i < N; i++) look({20'h40000 + 20'(i), 12'h0}, 8'd9, 2'd0, 0, "R9 no eviction while free");
    // full: one new mapping displaces exactly one
    @(negedge clk);
    rf_valid = 1; rf_vpn = 20'h50000; rf_pid = 8'd9; rf_ppn = 18'h0_5000; rf_perm = 3'b111;
    @(negedge clk);
    rf_valid = 0;
    hits = 0;
    for (int i = 0; i <= N; i++) begin
      @(negedge clk);
      lk_valid = 1; lk_vaddr = {(i == N) ? 20'h50000 : 20'h40000 + 20'(i), 12'h0};
      lk_pid = 8'd9; lk_acc = 2'd0; lk_super = 1;
      @(negedge clk);
      lk_valid = 0;
      hits += rs_hit;
      if (i == N) chk(rs_hit && rs_paddr == 30'h0500_0000, "R9 new mapping present", rs_paddr, 30'h0500_0000);
    end
    chk(hits == N, "R9 exactly one displaced", hits, N);
    flush();

    // random phase
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 99);
      logic [19:0] vpn = 20'h00100 + 20'($urandom_range(0, 9));
      logic [PW-1:0] pid = PW'($urandom_range(1, 3));
      if (op < 60)
        look({vpn, 12'($urandom)}, pid, 2'($urandom_range(0, 3)), ($urandom_range(0, 7) == 0),
             "R3 R4 R6 R7 random lookup");
      else if (op < 88) begin
        if (m_count() < N || m_find(vpn, pid) >= 0)
          refill(vpn, pid, 18'($urandom), 3'($urandom));
        else
          purge(pid);
      end else if (op < 97)
        purge(pid);
      else
        flush();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule